// File: doc/BRIEF.md
# AES Block Encryption Engine

This block encrypts one 128-bit block at a time with AES, using a 128-, 192- or 256-bit key. A block can be encrypted on its own (electronic codebook) or chained to the previous ciphertext (cipher block chaining). The host drives key, IV, mode, key size and plaintext onto the slave-style inputs and pulses `start`. It then waits for the one-cycle `done` strobe and reads the ciphertext from `dout`.

Each round passes through four register stages. The first maps every byte into the composite field GF((2^4)^2). The second inverts it there. The third maps it back, applies the affine step and shifts the rows. The fourth mixes the columns and adds the round key. The matrices for the mapping into and out of the composite field are derived while the design elaborates, not written out by hand. The schedule yields one key word per cycle, so each round's key is ready in its final stage and no table of round keys is stored.

Top module: `aes_enc_pipe`

## Requirements
- R1: `key_len` selects the key size: 2'b00 selects 128 bits (10 rounds), 2'b01 selects 192 bits (12 rounds), and 2'b10 or 2'b11 selects 256 bits (14 rounds). The key is left-aligned in `key_in`, so a 128-bit key sits in bits [255:128] and a 192-bit key in bits [255:64].
- R2: With `cbc_mode` low, `dout` is the standard AES encryption of `din`, and `iv_in` has no effect on it.
- R3: With `cbc_mode` high, `din` is XORed before encryption with `iv_in` when `new_msg` is high at start. When `new_msg` is low, it is XORed with the last ciphertext the block produced.
- R4: `done` rises 4*(rounds+1) cycles after the edge that accepts `start`: 44, 52 or 60 cycles.
- R5: `done` is high for exactly one cycle. `dout` keeps its value until the next completion.
- R6: A `start` that arrives while `busy` is high is ignored. The block in flight finishes with its own inputs, and no extra completion follows.
- R7: After reset, `done` and `busy` are low and `dout` is zero.
- R8: Byte 0 of the AES state is `din[127:120]`, and the state is filled column by column. `dout` uses the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; sampled only while idle |
| cbc_mode | input | 1 | 1 = chain to previous ciphertext, 0 = independent blocks |
| new_msg | input | 1 | With chaining, use `iv_in` for this block |
| key_len | input | 2 | Key size select |
| key_in | input | 256 | Cipher key, left-aligned |
| iv_in | input | 128 | Initialisation vector |
| din | input | 128 | Plaintext block |
| dout | output | 128 | Ciphertext block |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | A block is in progress |

## Verification
Published known-answer vectors for all three key sizes tell apart errors in the round count, in the schedule branches that depend on key length, and in the S-box. A single wrong S-box entry or a wrong field mapping breaks every such vector. A second 128-bit vector with an unrelated key and plaintext guards against a match that holds for one input only. A two-block chained message, restarted with a fresh IV, separates the use of the IV from the use of the previous ciphertext. An independent-mode block given a nonzero IV shows whether the IV leaks into that mode. A second start pulse during a run shows whether the engine restarts or latches new inputs while busy.

// File: rtl/aes_enc_pipe.sv
module aes_enc_pipe (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cbc_mode,
  input  logic         new_msg,
  input  logic [1:0]   key_len,
  input  logic [255:0] key_in,
  input  logic [127:0] iv_in,
  input  logic [127:0] din,
  output logic [127:0] dout,
  output logic         done,
  output logic         busy
);

  function automatic logic [3:0] g16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p, t;
    p = 4'h0;
    t = a;
    for (int k = 0; k < 4; k++) begin
      if (b[k]) p = p ^ t;
      t = {t[2:0], 1'b0} ^ (t[3] ? 4'h3 : 4'h0);
    end
    return p;
  endfunction

  function automatic logic [3:0] g16_inv(input logic [3:0] a);
    logic [3:0] a2, a4, a8;
    a2 = g16_mul(a, a);
    a4 = g16_mul(a2, a2);
    a8 = g16_mul(a4, a4);
    return g16_mul(g16_mul(a2, a4), a8);
  endfunction

  function automatic logic [3:0] find_lam();
    logic [3:0] res;
    logic hit;
    res = 4'h0;
    for (int l = 15; l >= 1; l--) begin
      hit = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((g16_mul(4'(t), 4'(t)) ^ 4'(t)) == 4'(l)) hit = 1'b1;
      if (!hit) res = 4'(l);
    end
    return res;
  endfunction

  localparam logic [3:0] LAM = find_lam();

  function automatic logic [7:0] c_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh;
    hh = g16_mul(a[7:4], b[7:4]);
    return {hh ^ g16_mul(a[7:4], b[3:0]) ^ g16_mul(a[3:0], b[7:4]),
            g16_mul(hh, LAM) ^ g16_mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [7:0] c_inv(input logic [7:0] a);
    logic [3:0] dl, di;
    dl = g16_mul(g16_mul(a[7:4], a[7:4]), LAM) ^ g16_mul(a[7:4], a[3:0]) ^ g16_mul(a[3:0], a[3:0]);
    di = g16_inv(dl);
    return {g16_mul(a[7:4], di), g16_mul(a[7:4] ^ a[3:0], di)};
  endfunction

  function automatic logic [7:0] find_root();
    logic [7:0] res, p1, p2, p3, p4, p8;
    res = 8'h00;
    for (int c = 255; c >= 1; c--) begin
      p1 = 8'(c);
      p2 = c_mul(p1, p1);
      p3 = c_mul(p2, p1);
      p4 = c_mul(p2, p2);
      p8 = c_mul(p4, p4);
      if ((p8 ^ p4 ^ p3 ^ p1 ^ 8'h01) == 8'h00) res = p1;
    end
    return res;
  endfunction

  function automatic logic [7:0] lin_map(input logic [63:0] cols, input logic [7:0] v);
    logic [7:0] o;
    o = 8'h00;
    for (int i = 0; i < 8; i++)
      if (v[i]) o = o ^ cols[8*i +: 8];
    return o;
  endfunction

  function automatic logic [63:0] build_to(input logic [7:0] r);
    logic [63:0] cols;
    logic [7:0] pw;
    cols = 64'h0;
    pw = 8'h01;
    for (int i = 0; i < 8; i++) begin
      cols[8*i +: 8] = pw;
      pw = c_mul(pw, r);
    end
    return cols;
  endfunction

  function automatic logic [63:0] build_from(input logic [63:0] tc);
    logic [63:0] fc;
    fc = 64'h0;
    for (int j = 0; j < 8; j++)
      for (int v = 0; v < 256; v++)
        if (lin_map(tc, 8'(v)) == (8'h01 << j)) fc[8*j +: 8] = 8'(v);
    return fc;
  endfunction

  localparam logic [7:0]  ROOT    = find_root();
  localparam logic [63:0] TO_CF   = build_to(ROOT);
  localparam logic [63:0] FROM_CF = build_from(TO_CF);

  function automatic logic [7:0] affine(input logic [7:0] a);
    return a ^ {a[6:0], a[7]} ^ {a[5:0], a[7:6]} ^ {a[4:0], a[7:5]} ^ {a[3:0], a[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    return affine(lin_map(FROM_CF, c_inv(lin_map(TO_CF, x))));
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [127:0] stage_map(input logic [127:0] s);
    logic [127:0] o;
    o = '0;
    for (int b = 0; b < 16; b++) o[8*b +: 8] = lin_map(TO_CF, s[8*b +: 8]);
    return o;
  endfunction

  function automatic logic [127:0] stage_inv(input logic [127:0] s);
    logic [127:0] o;
    o = '0;
    for (int b = 0; b < 16; b++) o[8*b +: 8] = c_inv(s[8*b +: 8]);
    return o;
  endfunction

  function automatic logic [127:0] stage_unmap_shift(input logic [127:0] s);
    logic [127:0] o;
    o = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        o[127 - 8*(r + 4*c) -: 8] = affine(lin_map(FROM_CF, s[127 - 8*(r + 4*((c + r) % 4)) -: 8]));
    return o;
  endfunction

  function automatic logic [127:0] stage_mix(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    o = '0;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127 - 32*c -: 8];
      a1 = s[119 - 32*c -: 8];
      a2 = s[111 - 32*c -: 8];
      a3 = s[103 - 32*c -: 8];
      o[127 - 32*c -: 32] = {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
                             a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
                             a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
                             xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
    end
    return o;
  endfunction

  logic [127:0] st, st_nx, chain_q, rk;
  logic [255:0] key_q;
  logic [1:0]   klen_q, ph;
  logic [3:0]   rnd, nk, nr;
  logic [2:0]   kpos;
  logic         past;
  logic [7:0]   rcon;
  logic [31:0]  win [8];
  logic [31:0]  prev, sub_in, sub_w, tmp, wnext;

  assign nk     = (klen_q == 2'd0) ? 4'd4 : (klen_q == 2'd1) ? 4'd6 : 4'd8;
  assign nr     = nk + 4'd6;
  assign prev   = win[0];
  assign sub_in = (kpos == 3'd0) ? {prev[23:0], prev[31:24]} : prev;
  assign sub_w  = {sbox(sub_in[31:24]), sbox(sub_in[23:16]), sbox(sub_in[15:8]), sbox(sub_in[7:0])};
  assign tmp    = (kpos == 3'd0) ? (sub_w ^ {rcon, 24'h0}) :
                  ((nk == 4'd8) && (kpos == 3'd4)) ? sub_w : prev;
  assign wnext  = past ? (win[3'(nk - 4'd1)] ^ tmp) : key_q[8'd255 - {kpos, 5'd0} -: 32];
  assign rk     = {win[2], win[1], win[0], wnext};

  always_comb begin
    st_nx = st;
    if (rnd == 4'd0) begin
      if (ph == 2'd3) st_nx = st ^ rk;
    end else begin
      case (ph)
        2'd0: st_nx = stage_map(st);
        2'd1: st_nx = stage_inv(st);
        2'd2: st_nx = stage_unmap_shift(st);
        default: st_nx = ((rnd == nr) ? st : stage_mix(st)) ^ rk;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0; chain_q <= '0; key_q <= '0; dout <= '0;
      klen_q <= '0; ph <= '0; rnd <= '0; kpos <= '0;
      past <= 1'b0; rcon <= 8'h01; done <= 1'b0; busy <= 1'b0;
      for (int k = 0; k < 8; k++) win[k] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          st     <= din ^ (cbc_mode ? (new_msg ? iv_in : chain_q) : 128'h0);
          key_q  <= key_in;
          klen_q <= key_len;
          busy   <= 1'b1;
          ph     <= '0;
          rnd    <= '0;
          kpos   <= '0;
          past   <= 1'b0;
          rcon   <= 8'h01;
        end
      end else begin
        st <= st_nx;
        ph <= ph + 2'd1;
        for (int k = 7; k > 0; k--) win[k] <= win[k-1];
        win[0] <= wnext;
        if (kpos == 3'(nk - 4'd1)) begin
          kpos <= '0;
          past <= 1'b1;
        end else begin
          kpos <= kpos + 3'd1;
        end
        if (past && kpos == 3'd0) rcon <= xtime(rcon);
        if (ph == 2'd3) begin
          rnd <= rnd + 4'd1;
          if (rnd == nr) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            dout    <= st_nx;
            chain_q <= st_nx;
          end
        end
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done wider than one cycle");

  assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dout)) else $error("dout moved without done");

  assert_key_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(key_q)) else $error("key reloaded while busy");

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)) else $error("done without a run");

  assert_round_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rnd <= nr)) else $error("round count beyond key size limit");

  assert_start_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy) else $error("idle start not accepted");

endmodule

// File: tb/aes_enc_pipe_tb_top.sv
module aes_enc_pipe_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, cbc_mode = 1'b0, new_msg = 1'b0;
  logic [1:0]   key_len = 2'd0;
  logic [255:0] key_in = '0;
  logic [127:0] iv_in = '0, din = '0;
  logic [127:0] dout;
  logic         done, busy;
  int           n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  aes_enc_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cbc_mode(cbc_mode), .new_msg(new_msg),
    .key_len(key_len), .key_in(key_in), .iv_in(iv_in), .din(din),
    .dout(dout), .done(done), .busy(busy)
  );

  localparam logic [255:0] K128  = {128'h000102030405060708090a0b0c0d0e0f, 128'h0};
  localparam logic [255:0] K192  = {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0};
  localparam logic [255:0] K256  = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [255:0] KSP   = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
  localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] P1    = 128'h6bc1bee22e409f96e93d7e117393172a;
  localparam logic [127:0] P2    = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
  localparam logic [127:0] IV0   = 128'h000102030405060708090a0b0c0d0e0f;

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      report();
    end
  end

  task automatic run_block(input logic [255:0] k, input logic [1:0] kl, input logic cbc,
                           input logic nm, input logic [127:0] iv, input logic [127:0] pt,
                           output logic [127:0] ct, output int lat);
    @(negedge clk);
    key_in = k; key_len = kl; cbc_mode = cbc; new_msg = nm; iv_in = iv; din = pt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    ct = dout;
  endtask

  task automatic t_reset();
    chk("R7 done", 128'(done), 128'h0);
    chk("R7 busy", 128'(busy), 128'h0);
    chk("R7 dout", dout, 128'h0);
  endtask

  task automatic t_kat_sizes();
    logic [127:0] ct; int lat;
    run_block(K128, 2'b00, 1'b0, 1'b0, '0, PT_A, ct, lat);
    chk("R1 R2 R8 aes128", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk("R4 latency 128", 128'(lat), 128'd44);
    run_block(K192, 2'b01, 1'b0, 1'b0, '0, PT_A, ct, lat);
    chk("R1 aes192", ct, 128'hdda97ca4864cdfe06eaf70a0ec0d7191);
    chk("R4 latency 192", 128'(lat), 128'd52);
    run_block(K256, 2'b10, 1'b0, 1'b0, '0, PT_A, ct, lat);
    chk("R1 aes256", ct, 128'h8ea2b7ca516745bfeafc49904b496089);
    chk("R4 latency 256", 128'(lat), 128'd60);
    run_block(K256, 2'b11, 1'b0, 1'b0, '0, PT_A, ct, lat);
    chk("R1 code 11 as 256", ct, 128'h8ea2b7ca516745bfeafc49904b496089);
  endtask

  task automatic t_second_vector();
    logic [127:0] ct; int lat;
    run_block(KSP, 2'b00, 1'b0, 1'b0, '0, 128'h3243f6a8885a308d313198a2e0370734, ct, lat);
    chk("R2 R8 second vector", ct, 128'h3925841d02dc09fbdc118597196a0b32);
  endtask

  task automatic t_ecb_iv_ignored();
    logic [127:0] ct; int lat;
    run_block(KSP, 2'b00, 1'b0, 1'b1, 128'hdeadbeef0123456789abcdeffedcba98, P1, ct, lat);
    chk("R2 iv ignored in ecb", ct, 128'h3ad77bb40d7a3660a89ecaf32466ef97);
  endtask

  task automatic t_cbc_chain();
    logic [127:0] ct; int lat;
    run_block(KSP, 2'b00, 1'b1, 1'b1, IV0, P1, ct, lat);
    chk("R3 cbc block 1", ct, 128'h7649abac8119b246cee98e9b12e9197d);
    run_block(KSP, 2'b00, 1'b1, 1'b0, IV0, P2, ct, lat);
    chk("R3 cbc block 2", ct, 128'h5086cb9b507219ee95db113a917678b2);
    run_block(KSP, 2'b00, 1'b1, 1'b1, IV0, P1, ct, lat);
    chk("R3 cbc restart", ct, 128'h7649abac8119b246cee98e9b12e9197d);
  endtask

  task automatic t_done_hold();
    logic [127:0] ct; int lat;
    run_block(K128, 2'b00, 1'b0, 1'b0, '0, PT_A, ct, lat);
    @(negedge clk);
    chk("R5 done one cycle", 128'(done), 128'h0);
    din = '0;
    repeat (3) @(negedge clk);
    chk("R5 dout held", dout, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
  endtask

  task automatic t_busy_start();
    int lat, dones;
    @(negedge clk);
    key_in = K128; key_len = 2'b00; cbc_mode = 1'b0; din = PT_A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    key_in = K256; key_len = 2'b10; din = P1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 11;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R6 in-flight result", dout, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk("R6 latency unchanged", 128'(lat), 128'd44);
    dones = 0;
    repeat (80) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R6 no extra completion", 128'(dones), 128'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_kat_sizes();
    t_second_vector();
    t_ecb_iv_ignored();
    t_cbc_chain();
    t_done_hold();
    t_busy_start();
    report();
  end
endmodule